// File: doc/BRIEF.md
# PCIe Root-Port Link Bring-Up Sequencer

This block takes a PCIe root port from reset to a usable link with no software involvement. One start pulse launches a fixed program of control-register writes, issued one per cycle through a plain write port. The program selects direct core mode, sets root-complex operation, the speed generation and the lane count, enables training, and then kicks off training.

Once training is started, the sequencer samples the link-state field of a status word. It takes the first sample right after the last write. After each failed sample it waits a programmable number of cycles before trying again. If the link reaches the active state within the allowed number of attempts, the sequencer writes the IO, memory and bus-master enables to the command register and raises `done_o`. If the attempts run out, it raises `timeout_o` instead.

The PHY, the real link state machine and add-in card reset timing sit outside this block.

Top module: `rp_link_bringup`

## Requirements
- R1: After reset, `wr_en_o`, `done_o` and `timeout_o` are low, and no write is issued until a start pulse arrives.
- R2: An accepted start produces eight writes on consecutive cycles, beginning in the cycle after the start edge, in this order (address : data):
  1. MODE : 0x0 (direct mode, the core mode bit 0 cleared)
  2. CTRL0 : root-complex flag
  3. CTRL2 : 0x17
  4. CTRL0 : adds the speed field
  5. CTRL0 : adds the lane field
  6. CTRL0 : adds the training enable
  7. CTRL2 : 0x57 (bit 6 added)
  8. LINKCTL : 0x20 (training start, bit 5)
- R3: Control word 0 carries the speed select in bits 1:0 (0 = Gen1, 1 = Gen2, 2 = Gen3), the root-complex flag in bit 2, the lane code in bits 4:3 (0 = x1, 1 = x2, 2 = x4, 3 = x8) and the training enable in bit 6. Its final value is 0x45 with the default Gen2 and x1 settings, and 0x5E with Gen3 and x8.
- R4: The training-start write to LINKCTL is issued only after a CTRL0 write with bit 6 set has been issued in the same run.
- R5: The link counts as up when bits 29:24 of `link_stat_i` hold a value of 0x10 or more. All other bits of `link_stat_i` are ignored.
- R6: The first link sample is taken in the cycle after the last program write. Each later sample follows `POLL_CYCLES` idle cycles. After `MAX_TRIES` failed samples, `timeout_o` rises on the next edge.
- R7: On link-up, exactly one write of 0x7 (IO, memory and bus-master enables) goes to the command address, and `done_o` rises on the following edge.
- R8: `done_o` and `timeout_o` are never high together. Each stays high until the next start pulse, which clears it on the start edge.
- R9: A start pulse that arrives while the sequence is running is ignored: the number of writes and the completion cycle do not change.
- R10: A run that times out issues no write to the command address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| link_stat_i | input | 32 | Status word holding the link-state field |
| wr_en_o | output | 1 | Register write strobe |
| wr_addr_o | output | ADDR_W | Register write address |
| wr_data_o | output | 32 | Register write data |
| done_o | output | 1 | Link up and enables written |
| timeout_o | output | 1 | Link did not come up within the retry limit |

## Verification
The bench builds the sequencer with `POLL_CYCLES` = 5 and `MAX_TRIES` = 4. This keeps the full retry ladder down to 27 cycles, so the exact timeout cycle and the retry spacing can be checked directly. A second instance with Gen3 and x8 settings runs alongside the first to show the control-word field encoding. Link-state values of 0x0F, 0x10 and 0x3F, with noise in the surrounding bits, cover the threshold. A start pulse injected during polling exercises the busy-ignore rule.

// File: rtl/rp_link_pkg.sv
package rp_link_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned NUM_STEPS = 8;
  localparam int unsigned STEP_W    = $clog2(NUM_STEPS);
  localparam logic [WORD_W-1:0] CMD_ENABLES = 32'h0000_0007;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_SAMPLE,
    ST_WAIT,
    ST_ENABLE,
    ST_DONE,
    ST_FAIL
  } seq_state_e;
endpackage

// File: rtl/rp_init_rom.sv
module rp_init_rom
  import rp_link_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned SPEED_SEL    = 1,
  parameter int unsigned LANE_SEL     = 0,
  parameter logic [ADDR_W-1:0] ADDR_MODE    = 16'h0100,
  parameter logic [ADDR_W-1:0] ADDR_CTRL0   = 16'h0200,
  parameter logic [ADDR_W-1:0] ADDR_CTRL2   = 16'h0208,
  parameter logic [ADDR_W-1:0] ADDR_LINKCTL = 16'h0050
) (
  input  logic [STEP_W-1:0] step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] data_o
);
  localparam logic [WORD_W-1:0] C0_RC   = 32'h0000_0004;
  localparam logic [WORD_W-1:0] C0_SPD  = C0_RC | WORD_W'(SPEED_SEL & 3);
  localparam logic [WORD_W-1:0] C0_LANE = C0_SPD | (WORD_W'(LANE_SEL & 3) << 3);
  localparam logic [WORD_W-1:0] C0_TRN  = C0_LANE | 32'h0000_0040;
  localparam logic [WORD_W-1:0] C2_BASE = 32'h0000_0017;
  localparam logic [WORD_W-1:0] C2_MAP  = C2_BASE | 32'h0000_0040;
  localparam logic [WORD_W-1:0] LC_TRN  = 32'h0000_0020;

  always_comb begin
    unique case (step_i)
      3'd0:    begin addr_o = ADDR_MODE;    data_o = '0;      end
      3'd1:    begin addr_o = ADDR_CTRL0;   data_o = C0_RC;   end
      3'd2:    begin addr_o = ADDR_CTRL2;   data_o = C2_BASE; end
      3'd3:    begin addr_o = ADDR_CTRL0;   data_o = C0_SPD;  end
      3'd4:    begin addr_o = ADDR_CTRL0;   data_o = C0_LANE; end
      3'd5:    begin addr_o = ADDR_CTRL0;   data_o = C0_TRN;  end
      3'd6:    begin addr_o = ADDR_CTRL2;   data_o = C2_MAP;  end
      default: begin addr_o = ADDR_LINKCTL; data_o = LC_TRN;  end
    endcase
  end
endmodule

// File: rtl/rp_poll_timer.sv
module rp_poll_timer #(
  parameter int unsigned POLL_CYCLES = 10_000_000,
  localparam int unsigned CNT_W = $clog2(POLL_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= CNT_W'(POLL_CYCLES - 1);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R6: an idle counter must not wrap
  a_r6_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !load_i) |=> expired_o);
endmodule

// File: rtl/rp_link_up_det.sv
module rp_link_up_det
  import rp_link_pkg::*;
#(
  parameter int unsigned FIELD_LSB = 24,
  parameter int unsigned FIELD_W   = 6,
  parameter int unsigned UP_CODE   = 'h10
) (
  input  logic [WORD_W-1:0] stat_i,
  output logic              up_o
);
  logic [FIELD_W-1:0] field;
  logic               unused_bits;

  assign field       = stat_i[FIELD_LSB +: FIELD_W];
  assign up_o        = (field >= FIELD_W'(UP_CODE));
  assign unused_bits = ^{stat_i[WORD_W-1:FIELD_LSB+FIELD_W], stat_i[FIELD_LSB-1:0]};
endmodule

// File: rtl/rp_link_bringup.sv
module rp_link_bringup
  import rp_link_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned POLL_CYCLES = 10_000_000,
  parameter int unsigned MAX_TRIES   = 10,
  parameter int unsigned SPEED_SEL   = 1,
  parameter int unsigned LANE_SEL    = 0,
  parameter logic [ADDR_W-1:0] ADDR_MODE    = 16'h0100,
  parameter logic [ADDR_W-1:0] ADDR_CTRL0   = 16'h0200,
  parameter logic [ADDR_W-1:0] ADDR_CTRL2   = 16'h0208,
  parameter logic [ADDR_W-1:0] ADDR_LINKCTL = 16'h0050,
  parameter logic [ADDR_W-1:0] ADDR_CMD     = 16'h0004
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] link_stat_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              done_o,
  output logic              timeout_o
);
  localparam int unsigned TRY_W = $clog2(MAX_TRIES + 1);

  seq_state_e        state_q;
  logic [STEP_W-1:0] step_q;
  logic [TRY_W-1:0]  tries_q;
  logic              link_up, tmr_load, tmr_expired, can_start;
  logic [ADDR_W-1:0] rom_addr;
  logic [WORD_W-1:0] rom_data;

  rp_init_rom #(
    .ADDR_W(ADDR_W), .SPEED_SEL(SPEED_SEL), .LANE_SEL(LANE_SEL),
    .ADDR_MODE(ADDR_MODE), .ADDR_CTRL0(ADDR_CTRL0),
    .ADDR_CTRL2(ADDR_CTRL2), .ADDR_LINKCTL(ADDR_LINKCTL)
  ) rom_i (
    .step_i(step_q), .addr_o(rom_addr), .data_o(rom_data)
  );

  rp_link_up_det det_i (.stat_i(link_stat_i), .up_o(link_up));

  rp_poll_timer #(.POLL_CYCLES(POLL_CYCLES)) tmr_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .expired_o(tmr_expired)
  );

  assign can_start = (state_q == ST_IDLE) || (state_q == ST_DONE) || (state_q == ST_FAIL);
  assign tmr_load  = (state_q == ST_SAMPLE) && !link_up;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      tries_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE, ST_FAIL: begin
          if (start_i) begin
            state_q <= ST_PROG;
            step_q  <= '0;
            tries_q <= '0;
          end
        end
        ST_PROG: begin
          if (step_q == STEP_W'(NUM_STEPS - 1)) state_q <= ST_SAMPLE;
          step_q <= step_q + 1'b1;
        end
        ST_SAMPLE: begin
          if (link_up)                                state_q <= ST_ENABLE;
          else if (tries_q == TRY_W'(MAX_TRIES - 1))  state_q <= ST_FAIL;
          else begin
            state_q <= ST_WAIT;
            tries_q <= tries_q + 1'b1;
          end
        end
        ST_WAIT:   if (tmr_expired) state_q <= ST_SAMPLE;
        ST_ENABLE: state_q <= ST_DONE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    wr_en_o   = 1'b0;
    wr_addr_o = '0;
    wr_data_o = '0;
    if (state_q == ST_PROG) begin
      wr_en_o   = 1'b1;
      wr_addr_o = rom_addr;
      wr_data_o = rom_data;
    end else if (state_q == ST_ENABLE) begin
      wr_en_o   = 1'b1;
      wr_addr_o = ADDR_CMD;
      wr_data_o = CMD_ENABLES;
    end
  end

  assign done_o    = (state_q == ST_DONE);
  assign timeout_o = (state_q == ST_FAIL);

  // checker state: training enable seen in this run
  logic train_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   train_seen_q <= 1'b0;
    else if (can_start && start_i)                 train_seen_q <= 1'b0;
    else if (wr_en_o && wr_addr_o == ADDR_CTRL0 && wr_data_o[6]) train_seen_q <= 1'b1;
  end

  a_r4_train_after_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_addr_o == ADDR_LINKCTL) |-> train_seen_q);

  a_r7_cmd_then_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_addr_o == ADDR_CMD) |=> done_o);

  a_r8_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && timeout_o));

  a_r8_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  a_r8_timeout_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_o && !start_i) |=> timeout_o);

  a_r9_busy_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_SAMPLE || state_q == ST_WAIT) && start_i) |=> (state_q != ST_PROG));

  a_r10_no_cmd_on_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !(wr_en_o && wr_addr_o == ADDR_CMD));

  a_r6_tries_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tries_q < TRY_W'(MAX_TRIES));
endmodule

// File: tb/rp_link_bringup_tb_top.sv
`timescale 1ns/1ps
module rp_link_bringup_tb_top;
  localparam int P = 5;
  localparam int M = 4;
  localparam logic [15:0] A_MODE = 16'h0100, A_C0 = 16'h0200, A_C2 = 16'h0208,
                          A_LC = 16'h0050, A_CMD = 16'h0004;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] link_stat = '0;
  logic        wr_en, done, tmo, alt_wr_en, alt_done, alt_tmo;
  logic [15:0] wr_addr, alt_wr_addr;
  logic [31:0] wr_data, alt_wr_data;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  rp_link_bringup #(.POLL_CYCLES(P), .MAX_TRIES(M)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .link_stat_i(link_stat),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .done_o(done), .timeout_o(tmo));

  rp_link_bringup #(.POLL_CYCLES(P), .MAX_TRIES(M), .SPEED_SEL(2), .LANE_SEL(3)) alt_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .link_stat_i(link_stat),
    .wr_en_o(alt_wr_en), .wr_addr_o(alt_wr_addr), .wr_data_o(alt_wr_data),
    .done_o(alt_done), .timeout_o(alt_tmo));

  logic [15:0] log_a [0:511];
  logic [31:0] log_d [0:511];
  logic [31:0] alt_d [0:511];
  int wtot = 0;

  always @(negedge clk) begin
    if (wr_en) begin
      if (wtot < 512) begin
        log_a[wtot] = wr_addr;
        log_d[wtot] = wr_data;
        alt_d[wtot] = alt_wr_en ? alt_wr_data : 32'hDEAD_BEEF;
      end
      wtot = wtot + 1;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // starts a run, returns the edge count at which done or timeout was seen
  task automatic run_seq(input logic [31:0] st0, input int set_at, input logic [31:0] st1,
                         input int busy_at, output int n);
    link_stat = st0;
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    n = 0;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (n == 1) check(!done && !tmo, "R8 clear on start", {done, tmo}, 0);
      if (n == set_at) link_stat = st1;
      if (n == busy_at) start = 1'b1;
      if (n == busy_at + 1) start = 1'b0;
      if (done || tmo) break;
    end
  endtask

  function automatic logic [31:0] exp_prog(input int s, input int spd, input int ln);
    logic [31:0] c0;
    c0 = 32'h4;
    case (s)
      0: return 32'h0;
      1: return c0;
      2: return 32'h17;
      3: return c0 | 32'(spd);
      4: return c0 | 32'(spd) | (32'(ln) << 3);
      5: return c0 | 32'(spd) | (32'(ln) << 3) | 32'h40;
      6: return 32'h57;
      default: return 32'h20;
    endcase
  endfunction

  function automatic logic [15:0] exp_addr(input int s);
    case (s)
      0: return A_MODE;
      1, 3, 4, 5: return A_C0;
      2, 6: return A_C2;
      default: return A_LC;
    endcase
  endfunction

  task automatic t_reset;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(!wr_en && !done && !tmo, "R1 reset idle", {wr_en, done, tmo}, 0);
    end
    check(wtot == 0, "R1 no writes", wtot, 0);
  endtask

  task automatic t_basic;
    int n, base;
    base = wtot;
    run_seq(32'h1000_0000, -1, '0, -1, n);
    check(done && !tmo, "R5 field 0x10 is up", {done, tmo}, 2);
    check(n == 10, "R7 done cycle", n, 10);
    check(wtot - base == 9, "R2 write count", wtot - base, 9);
    for (int s = 0; s < 8; s++) begin
      check(log_a[base+s] == exp_addr(s), "R2 addr", log_a[base+s], exp_addr(s));
      check(log_d[base+s] == exp_prog(s, 1, 0), "R2 data", log_d[base+s], exp_prog(s, 1, 0));
    end
    check(log_d[base+5] == 32'h45, "R3 ctrl0 gen2 x1", log_d[base+5], 32'h45);
    check(alt_d[base+5] == 32'h5E, "R3 ctrl0 gen3 x8", alt_d[base+5], 32'h5E);
    check(alt_d[base+3] == 32'h6, "R3 speed field", alt_d[base+3], 32'h6);
    check(log_a[base+8] == A_CMD && log_d[base+8] == 32'h7, "R7 cmd write",
          log_d[base+8], 32'h7);
  endtask

  task automatic t_hold;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      link_stat = 32'(i);
    end
    check(done && !tmo, "R8 done held", {done, tmo}, 2);
  endtask

  task automatic t_retry_busy;
    int n, base;
    base = wtot;
    run_seq(32'h0F00_0000, 9, 32'h1000_0000, 11, n);
    check(done, "R6 second sample succeeds", done, 1);
    check(n == 16, "R6 retry spacing", n, 16);
    check(wtot - base == 9, "R9 busy start ignored", wtot - base, 9);
  endtask

  task automatic t_timeout;
    int n, base;
    bit cmd_seen;
    base = wtot;
    run_seq(32'hCFFF_FFFF, -1, '0, -1, n);
    check(tmo && !done, "R5 field 0x0F is down", {done, tmo}, 1);
    check(n == 9 + (M - 1) * (P + 1), "R6 timeout cycle", n, 9 + (M - 1) * (P + 1));
    cmd_seen = 1'b0;
    for (int i = base; i < wtot; i++) if (log_a[i] == A_CMD) cmd_seen = 1'b1;
    check(!cmd_seen && (wtot - base == 8), "R10 no cmd on timeout", wtot - base, 8);
    for (int i = 0; i < 10; i++) @(negedge clk);
    check(tmo && !done, "R8 timeout held", {done, tmo}, 1);
  endtask

  task automatic t_max_field;
    int n;
    run_seq(32'h3F00_0000, -1, '0, -1, n);
    check(done && n == 10, "R5 field 0x3F is up", n, 10);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_hold();
    t_retry_busy();
    t_timeout();
    t_max_field();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule